// File: doc/BRIEF.md
# Reconfigurable SIMD Booth Multiply-Accumulator

This block is a signed multiply-accumulate datapath. It takes two 32-bit operands and a 64-bit addend and returns a 64-bit result. A 2-bit mode input sets the lane layout:

- one 32×32 product plus a 64-bit addend;
- two independent 16×16 products, each plus a 32-bit addend;
- four independent 8×8 products, each plus a 16-bit addend.

In every mode, lane k of an operand sits in the same bit positions: bits `[w*k +: w]`, where w is the lane width. Result lane k sits in bits `[2w*k +: 2w]`.

The multiplier operand is recoded in radix-4 Booth groups. This gives exactly 16 partial-product rows in every mode. Each row is built three ways, one per lane width. A row multiplexer driven by the mode picks one of them.

Each row candidate does three things:
- masks the multiplicand down to its own lane;
- sign-extends it with that lane's sign;
- clears every bit outside the lane's result field.

Partial products of different lanes therefore never overlap. The rows and the addend are compressed by a chain of carry-save stages. A segmented carry-propagate adder then finishes the sum. In both the compressor chain and the final adder, a carry is dropped wherever it would enter a lane boundary. The result is registered and comes out together with a valid flag one clock after the request.

Top module: `smac_simd`

## Requirements
- R1: With mode 00, the registered result equals the signed product of `a` and `b` plus `z`, taken modulo 2^64.
- R2: With mode 01, result bits `[32k+31:32k]` (k = 0, 1) equal the signed product of `a[16k+15:16k]` and `b[16k+15:16k]` plus `z[32k+31:32k]`, modulo 2^32.
- R3: With mode 10, result bits `[16k+15:16k]` (k = 0..3) equal the signed product of `a[8k+7:8k]` and `b[8k+7:8k]` plus `z[16k+15:16k]`, modulo 2^16.
- R4: Mode 11 is reserved and gives the same result as mode 00 for the same operands.
- R5: A lane's result depends only on that lane's operand and addend bits. Wrap-around in one lane never changes a neighbouring lane, and a lane whose multiplicand is zero returns its addend unchanged.
- R6: `out_vld` is high in exactly the cycle after a cycle with `in_vld` high, and low otherwise.
- R7: `res` loads only on a cycle with `in_vld` high and holds its value otherwise, whatever the other inputs do.
- R8: During reset and after it, until the first request, `out_vld` is 0 and `res` is all zeros.
- R9: A zero multiplier operand returns the addend unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request: operands are valid this cycle |
| mode | input | 2 | Lane layout: 00 one lane, 01 two lanes, 10 four lanes, 11 same as 00 |
| a | input | 32 | Packed signed multiplicand lanes |
| b | input | 32 | Packed signed multiplier lanes |
| z | input | 64 | Packed signed addend lanes |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res | output | 64 | Packed results, each modulo twice its lane width |

## Verification
Each mode is driven with seeded random operands and compared against a per-lane signed reference. Random values mostly test Booth digit selection and sign extension inside a lane.

Lanes that all hold the most negative value test the one case where a doubled, negated multiple overflows the lane width. Lanes that pair an addend of minus one with a product of one force a carry into every lane boundary, so any carry that leaks between lanes shows up at once.

Zero multipliers, zero multiplicands in a single lane, and the reserved mode tell apart faults in the row multiplexer, the lane masks and the mode decode.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic [1:0] {
        MODE_X1  = 2'b00,
        MODE_X2  = 2'b01,
        MODE_X4  = 2'b10,
        MODE_RSV = 2'b11
    } mac_mode_e;

endpackage

// File: rtl/smac_booth_rows.sv
module smac_booth_rows
    import smac_pkg::*;
#(
    parameter int W = 32
) (
    input  mac_mode_e                       mode,
    input  logic [W-1:0]                    a,
    input  logic [W-1:0]                    b,
    output logic [W/2-1:0][2*W-1:0]         rows
);
    localparam int ACC  = 2 * W;
    localparam int ROWS = W / 2;

    // Booth digit times the multiplicand, then shifted, trimmed to the lane and placed.
    function automatic logic [ACC-1:0] lane_pp(
        input logic [2:0]     grp,
        input logic [ACC-1:0] mc,
        input int             sh,
        input logic [ACC-1:0] keep,
        input int             base
    );
        logic [ACC-1:0] m;
        case (grp)
            3'b001, 3'b010: m = mc;
            3'b011:         m = mc << 1;
            3'b100:         m = -(mc << 1);
            3'b101, 3'b110: m = -mc;
            default:        m = '0;
        endcase
        return ((m << sh) & keep) << base;
    endfunction

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int P = 2 * r;

        // v = 0: full width, v = 1: half width, v = 2: quarter width
        for (genvar v = 0; v < 3; v++) begin : g_var
            localparam int LW = W >> v;
            localparam int K  = P / LW;
            localparam int J  = P % LW;
            localparam logic [ACC-1:0] KEEP = {ACC{1'b1}} >> (ACC - 2 * LW);

            logic [2:0]     grp;
            logic [ACC-1:0] mc;
            logic [ACC-1:0] pp;

            if (J == 0) begin : g_first
                assign grp = {b[P+1], b[P], 1'b0};
            end else begin : g_inner
                assign grp = {b[P+1], b[P], b[P-1]};
            end

            assign mc = {{(ACC-LW){a[K*LW+LW-1]}}, a[K*LW +: LW]};
            assign pp = lane_pp(grp, mc, J, KEEP, 2 * LW * K);
        end

        always_comb begin
            case (mode)
                MODE_X2: rows[r] = g_var[1].pp;
                MODE_X4: rows[r] = g_var[2].pp;
                default: rows[r] = g_var[0].pp;
            endcase
        end
    end

endmodule

// File: rtl/smac_csa_chain.sv
module smac_csa_chain #(
    parameter int ACC = 64,
    parameter int N   = 17
) (
    input  logic [N-1:0][ACC-1:0] ops,
    input  logic [ACC-1:0]        kill,
    output logic [ACC-1:0]        sum,
    output logic [ACC-1:0]        cry
);
    always_comb begin
        logic [ACC-1:0] s;
        logic [ACC-1:0] c;
        logic [ACC-1:0] t;
        s = ops[0];
        c = ops[1];
        for (int i = 2; i < N; i++) begin
            t = s ^ c ^ ops[i];
            c = (((s & c) | (s & ops[i]) | (c & ops[i])) << 1) & ~kill;
            s = t;
        end
        sum = s;
        cry = c;
    end

endmodule

// File: rtl/smac_seg_add.sv
module smac_seg_add #(
    parameter int ACC = 64
) (
    input  logic [ACC-1:0] x,
    input  logic [ACC-1:0] y,
    input  logic [ACC-1:0] kill,
    output logic [ACC-1:0] sum
);
    always_comb begin
        logic cy;
        logic ci;
        cy = 1'b0;
        for (int i = 0; i < ACC; i++) begin
            ci     = cy & ~kill[i];
            sum[i] = x[i] ^ y[i] ^ ci;
            cy     = (x[i] & y[i]) | (ci & (x[i] ^ y[i]));
        end
    end

endmodule

// File: rtl/smac_simd.sv
module smac_simd
    import smac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [1:0]     mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [2*W-1:0] z,
    output logic           out_vld,
    output logic [2*W-1:0] res
);
    localparam int ACC  = 2 * W;
    localparam int ROWS = W / 2;
    localparam int NOPS = ROWS + 1;
    localparam int QRES = W / 2;   // result width of a quarter-width lane
    localparam int HRES = W;       // result width of a half-width lane

    typedef struct packed {
        logic           vld;
        logic [ACC-1:0] res;
    } state_t;

    mac_mode_e                 mode_e;
    logic [ROWS-1:0][ACC-1:0]  rows;
    logic [NOPS-1:0][ACC-1:0]  ops;
    logic [ACC-1:0]            kill;
    logic [ACC-1:0]            cs_sum;
    logic [ACC-1:0]            cs_cry;
    logic [ACC-1:0]            total;
    state_t                    st_d, st_q;

    assign mode_e = mac_mode_e'(mode);

    // kill[i] = 1 drops any carry entering bit i (a lane boundary)
    always_comb begin
        kill = '0;
        for (int i = 1; i < ACC; i++) begin
            if (mode_e == MODE_X4 && (i % QRES) == 0) kill[i] = 1'b1;
            if (mode_e == MODE_X2 && (i % HRES) == 0) kill[i] = 1'b1;
        end
    end

    smac_booth_rows #(.W(W)) u_rows (
        .mode (mode_e),
        .a    (a),
        .b    (b),
        .rows (rows)
    );

    assign ops = {z, rows};

    smac_csa_chain #(.ACC(ACC), .N(NOPS)) u_csa (
        .ops  (ops),
        .kill (kill),
        .sum  (cs_sum),
        .cry  (cs_cry)
    );

    smac_seg_add #(.ACC(ACC)) u_cpa (
        .x    (cs_sum),
        .y    (cs_cry),
        .kill (kill),
        .sum  (total)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) st_d.res = total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign res     = st_q.res;

endmodule

module smac_simd_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_vld,
    input logic [1:0]     mode,
    input logic [W-1:0]   a,
    input logic [W-1:0]   b,
    input logic [2*W-1:0] z,
    input logic           out_vld,
    input logic [2*W-1:0] res
);
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res));

    a_r9_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && b == '0) |=> res == $past(z));

    a_r5_quad_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b10 && a[W/4-1:0] == '0) |=> res[W/2-1:0] == $past(z[W/2-1:0]));

    a_r5_dual_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b01 && a[W-1:W/2] == '0) |=> res[2*W-1:W] == $past(z[2*W-1:W]));

    // R8: cleared state while reset is held
    always @(posedge clk) begin
        if (!rst_n) a_r8_reset_clear: assert (!out_vld && res == '0);
    end

endmodule

bind smac_simd smac_simd_chk #(.W(W)) u_chk (.*);

// File: tb/tb_smac_simd.sv
`timescale 1ns/1ps
module tb_smac_simd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [63:0] z = '0;
    logic        out_vld;
    logic [63:0] res;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    smac_simd #(.W(32)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode),
        .a(a), .b(b), .z(z), .out_vld(out_vld), .res(res)
    );

    function automatic logic [63:0] ref_mac(logic [1:0] m, logic [31:0] x, logic [31:0] y,
                                            logic [63:0] acc);
        logic [63:0] r;
        r = '0;
        case (m)
            2'b01: begin
                for (int k = 0; k < 2; k++) begin
                    logic signed [31:0] px, py;
                    px = $signed(x[16*k +: 16]);
                    py = $signed(y[16*k +: 16]);
                    r[32*k +: 32] = px * py + acc[32*k +: 32];
                end
            end
            2'b10: begin
                for (int k = 0; k < 4; k++) begin
                    logic signed [15:0] px, py;
                    px = $signed(x[8*k +: 8]);
                    py = $signed(y[8*k +: 8]);
                    r[16*k +: 16] = px * py + acc[16*k +: 16];
                end
            end
            default: begin
                logic signed [63:0] px, py;
                px = $signed(x);
                py = $signed(y);
                r = px * py + acc;
            end
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request, then sample one cycle later away from the edge.
    task automatic run_op(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y,
                          input logic [63:0] acc, input logic [63:0] exp, input string req);
        @(negedge clk);
        in_vld = 1'b1; mode = m; a = x; b = y; z = acc;
        @(negedge clk);
        in_vld = 1'b0;
        check(out_vld == 1'b1, {req, " valid"}, {63'd0, out_vld}, 64'd1);
        check(res == exp, req, res, exp);
    endtask

    task automatic t_reset;
        check(out_vld == 1'b0, "R8 valid in reset", {63'd0, out_vld}, 64'd0);
        check(res == '0, "R8 result in reset", res, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0, "R8 valid after reset", {63'd0, out_vld}, 64'd0);
        check(res == '0, "R8 result after reset", res, 64'd0);
    endtask

    task automatic t_single;
        // R1 fixed values
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 64'd0, 64'h4000_0000_0000_0000, "R1 min*min");
        run_op(2'b00, 32'hFFFF_FFFF, 32'd7, 64'd10, 64'd3, "R1 -1*7+10");
        for (int i = 0; i < 200; i++) begin
            logic [31:0] x, y;
            logic [63:0] acc;
            x = $urandom; y = $urandom; acc = {$urandom, $urandom};
            run_op(2'b00, x, y, acc, ref_mac(2'b00, x, y, acc), "R1 random");
        end
    endtask

    task automatic t_dual;
        run_op(2'b01, 32'h8000_8000, 32'h8000_8000, 64'd0, 64'h4000_0000_4000_0000, "R2 min*min");
        for (int i = 0; i < 200; i++) begin
            logic [31:0] x, y;
            logic [63:0] acc;
            x = $urandom; y = $urandom; acc = {$urandom, $urandom};
            run_op(2'b01, x, y, acc, ref_mac(2'b01, x, y, acc), "R2 random");
        end
    endtask

    task automatic t_quad;
        run_op(2'b10, 32'h8080_8080, 32'h8080_8080, 64'd0, 64'h4000_4000_4000_4000, "R3 min*min");
        run_op(2'b10, 32'h7F80_017F, 32'h7F80_FF81, 64'h0000_0000_0000_0000,
               ref_mac(2'b10, 32'h7F80_017F, 32'h7F80_FF81, 64'd0), "R3 extremes");
        for (int i = 0; i < 200; i++) begin
            logic [31:0] x, y;
            logic [63:0] acc;
            x = $urandom; y = $urandom; acc = {$urandom, $urandom};
            run_op(2'b10, x, y, acc, ref_mac(2'b10, x, y, acc), "R3 random");
        end
    endtask

    task automatic t_reserved;
        for (int i = 0; i < 50; i++) begin
            logic [31:0] x, y;
            logic [63:0] acc;
            x = $urandom; y = $urandom; acc = {$urandom, $urandom};
            run_op(2'b11, x, y, acc, ref_mac(2'b00, x, y, acc), "R4 reserved as single");
        end
    endtask

    task automatic t_isolation;
        // every lane: 1*1 + (-1) wraps to zero with a carry at each boundary
        run_op(2'b10, 32'h0101_0101, 32'h0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R5 quad wrap");
        run_op(2'b01, 32'h0001_0001, 32'h0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R5 dual wrap");
        // lane 1 multiplicand zero, lane 0 overflows: lane 1 must return its addend
        run_op(2'b10, 32'h0000_0080, 32'h5A5A_5A80, 64'h0000_0000_1234_7FFF,
               64'h0000_0000_1234_BFFF, "R5 quad zero lane");
    endtask

    task automatic t_zero_mult;
        run_op(2'b00, 32'hDEAD_BEEF, 32'd0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R9 single");
        run_op(2'b01, 32'hDEAD_BEEF, 32'd0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, "R9 dual");
        run_op(2'b10, 32'hDEAD_BEEF, 32'd0, 64'h8000_7FFF_0001_FFFF, 64'h8000_7FFF_0001_FFFF, "R9 quad");
    endtask

    task automatic t_hold;
        logic [63:0] held;
        run_op(2'b00, 32'd3, 32'd5, 64'd1, 64'd16, "R7 load");
        held = res;
        @(negedge clk);
        mode = 2'b10; a = 32'h1234_5678; b = 32'h9ABC_DEF0; z = '1;
        @(negedge clk);
        check(out_vld == 1'b0, "R6 idle valid", {63'd0, out_vld}, 64'd0);
        check(res == held, "R7 hold without request", res, held);
        @(negedge clk);
        check(res == held, "R7 hold second cycle", res, held);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_dual();
        t_quad();
        t_reserved();
        t_isolation();
        t_zero_mult();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule